// File: doc/BRIEF.md
# Serial Register Access Slave

This block is the serial front end of a small clock/calendar device. An external master talks to it over a four-wire SPI link. The chip select is active high, and the clock idles low with clock phase 1. In that mode the master changes MOSI on the rising SCLK edge and samples MISO on the falling edge. Words are 8 bits, most significant bit first. The block samples the SPI pins with its own system clock, which must run well above SCLK. At the default two-stage synchronizer a 100 MHz system clock serves an SCLK of up to 2 MHz.

The first byte of every transfer is a command byte. Its top bit selects the direction, and its lower seven bits give the start address. Every later byte moves one register, and the address steps up by one after each byte and wraps from the top of the space back to zero. This lets the time, alarm or control groups move in one burst. The space holds the following:
- time and two alarm banks at the bottom;
- the control register at 0x0F, the status register at 0x10 and a charger configuration register at 0x11;
- a 96-byte RAM window at 0x20 to 0x7F.

Addresses 0x12 to 0x1F are unused. The counters, the alarm comparators and the RAM sit behind a simple register port of address, read strobe, write strobe and data. A write-protect level taken from the control register blocks writes everywhere except to the control register itself.

Top module: `spi_reg_slave`

## Requirements
- R1: A command byte with bit 7 set opens a write transfer, and one with bit 7 clear opens a read transfer. Bits 6:0 give the first register address.
- R2: In a write transfer, each complete data byte gives exactly one single-cycle `reg_wr_o` pulse. The pulse carries the byte, received MSB first, on `reg_wdata_o` and the start address plus the byte index on `reg_addr_o`.
- R3: In a read transfer, each data-byte slot gives exactly one `reg_rd_o` pulse, issued only after the first rising SCLK edge of that slot. The fetched byte appears on `spi_miso_o` MSB first, valid at every falling SCLK edge of the slot.
- R4: While `wp_i` is 1, write bytes aimed at any address other than 0x0F give no write strobe, and the target keeps its value. Writes to 0x0F still take effect.
- R5: Read data from 0x0F has bits 5:3 forced to 0. Read data from 0x10 has bits 7:2 forced to 0. Other mapped addresses return `reg_rdata_i` unchanged.
- R6: Addresses 0x12 to 0x1F never give a strobe. Reads from them return 0x00.
- R7: During a burst the address steps from 0x7F to 0x00.
- R8: Dropping chip select at any bit ends the transfer. A partial byte has no effect, and the next transfer starts with a new command byte.
- R9: Under reset all strobes are 0 and `spi_miso_o` is 0.
- R10: `spi_miso_o` is 0 during the command byte, during write transfers and while chip select is inactive.
- R11: A write transfer never gives a read strobe, a read transfer never gives a write strobe, and a strobe never lasts two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_sclk_i | input | 1 | SPI serial clock, idle low |
| spi_cs_i | input | 1 | SPI chip select, active high |
| spi_mosi_i | input | 1 | Serial data from master |
| spi_miso_o | output | 1 | Serial data to master |
| wp_i | input | 1 | Write-protect level from the control register |
| reg_addr_o | output | 7 | Register port address |
| reg_wr_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rd_o | output | 1 | Register read strobe |
| reg_rdata_i | input | 8 | Register read data, valid in the cycle of `reg_rd_o` |

## Verification
Bursts are driven as bit-level SPI frames over several address patterns:
- The seven time registers, and RAM bursts, separate correct stepping from stuck or skipped addresses.
- A burst across 0x7F separates wrapping from running past the top.
- Control, status and the unused gap separate read masking and strobe suppression from plain pass-through.

A protect-then-unprotect sequence writes the control register in mid-burst. It shows whether protection follows the current control value byte by byte. Transfers cut off in the command byte and in a data byte show whether a partial byte can leak a strobe.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int ADDR_W      = 7;
  localparam int DATA_W      = 8;
  localparam int WR_FLAG_BIT = DATA_W - 1;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h0F;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 7'h10;
  localparam logic [ADDR_W-1:0] CFG_LAST  = 7'h11;
  localparam logic [ADDR_W-1:0] RAM_BASE  = 7'h20;

  localparam logic [DATA_W-1:0] CTRL_RD_MASK = 8'hC7;
  localparam logic [DATA_W-1:0] STAT_RD_MASK = 8'h03;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_e;

  function automatic logic addr_mapped(input logic [ADDR_W-1:0] a);
    return (a <= CFG_LAST) || (a >= RAM_BASE);
  endfunction

  function automatic logic [DATA_W-1:0] read_mask(input logic [ADDR_W-1:0] a);
    if (a == CTRL_ADDR)      return CTRL_RD_MASK;
    else if (a == STAT_ADDR) return STAT_RD_MASK;
    else                     return '1;
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[0] <= '0;
        else         stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_i,
  input  logic              mosi_i,
  output logic              slot_start_o,
  output logic              bit_rise_o,
  output logic              word_done_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic             sclk_q;
  logic [CNT_W-1:0] cnt;
  logic [WORD_W-1:0] sh;
  logic             rise, fall;

  assign rise = cs_i &  sclk_i & ~sclk_q;
  assign fall = cs_i & ~sclk_i &  sclk_q;

  // first rising edge of a word opens the slot; later ones move MISO
  assign slot_start_o = rise && (cnt == '0);
  assign bit_rise_o   = rise && (cnt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= 1'b0;
      cnt         <= '0;
      sh          <= '0;
      word_done_o <= 1'b0;
      word_o      <= '0;
    end else begin
      sclk_q      <= sclk_i;
      word_done_o <= 1'b0;
      if (!cs_i) begin
        cnt <= '0;
      end else if (fall) begin
        sh <= {sh[WORD_W-2:0], mosi_i};
        if (cnt == CNT_LAST) begin
          cnt         <= '0;
          word_done_o <= 1'b1;
          word_o      <= {sh[WORD_W-2:0], mosi_i};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_access_ctrl.sv
module spi_access_ctrl
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              word_done_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              slot_start_i,
  input  logic              wp_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  output logic              load_o,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              read_phase_o
);
  phase_e            phase;
  logic [ADDR_W-1:0] ptr;
  logic              wr_ok;

  assign wr_ok        = addr_mapped(ptr) && (!wp_i || (ptr == CTRL_ADDR));
  assign read_phase_o = (phase == PH_READ);
  assign tx_word_o    = addr_mapped(reg_addr_o) ? (rdata_i & read_mask(reg_addr_o)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase       <= PH_CMD;
      ptr         <= '0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      reg_wr_o    <= 1'b0;
      reg_rd_o    <= 1'b0;
      load_o      <= 1'b0;
    end else begin
      reg_wr_o <= 1'b0;
      reg_rd_o <= 1'b0;
      load_o   <= 1'b0;
      if (!cs_i) begin
        phase <= PH_CMD;
      end else if (word_done_i) begin
        unique case (phase)
          PH_CMD: begin
            ptr   <= word_i[ADDR_W-1:0];
            phase <= word_i[WR_FLAG_BIT] ? PH_WRITE : PH_READ;
          end
          PH_WRITE: begin
            reg_addr_o  <= ptr;
            reg_wdata_o <= word_i;
            reg_wr_o    <= wr_ok;
            ptr         <= ptr + 1'b1;
          end
          default: ;
        endcase
      end else if (slot_start_i && (phase == PH_READ)) begin
        // fetch on demand: no read strobe for a slot the master never opens
        reg_addr_o <= ptr;
        reg_rd_o   <= addr_mapped(ptr);
        load_o     <= 1'b1;
        ptr        <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              shift_i,
  output logic              miso_o
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh     <= '0;
      miso_o <= 1'b0;
    end else if (!cs_i) begin
      sh     <= '0;
      miso_o <= 1'b0;
    end else if (load_i) begin
      miso_o <= data_i[WORD_W-1];
      sh     <= {data_i[WORD_W-2:0], 1'b0};
    end else if (shift_i) begin
      miso_o <= sh[WORD_W-1];
      sh     <= {sh[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_sclk_i,
  input  logic              spi_cs_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  input  logic              wp_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int PIN_W = 3;

  logic [PIN_W-1:0]  pins_raw, pins_s;
  logic              sclk_s, cs_s, mosi_s;
  logic              slot_start, bit_rise, word_done;
  logic [DATA_W-1:0] word;
  logic              load, read_phase;
  logic [DATA_W-1:0] tx_word;

  assign pins_raw = {spi_sclk_i, spi_cs_i, spi_mosi_i};
  assign {sclk_s, cs_s, mosi_s} = pins_s;

  spi_in_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_s)
  );

  spi_bit_engine #(.WORD_W(DATA_W)) u_bits (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sclk_i       (sclk_s),
    .cs_i         (cs_s),
    .mosi_i       (mosi_s),
    .slot_start_o (slot_start),
    .bit_rise_o   (bit_rise),
    .word_done_o  (word_done),
    .word_o       (word)
  );

  spi_access_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_i         (cs_s),
    .word_done_i  (word_done),
    .word_i       (word),
    .slot_start_i (slot_start),
    .wp_i         (wp_i),
    .rdata_i      (reg_rdata_i),
    .reg_addr_o   (reg_addr_o),
    .reg_wr_o     (reg_wr_o),
    .reg_wdata_o  (reg_wdata_o),
    .reg_rd_o     (reg_rd_o),
    .load_o       (load),
    .tx_word_o    (tx_word),
    .read_phase_o (read_phase)
  );

  spi_tx_shifter #(.WORD_W(DATA_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_i    (cs_s),
    .load_i  (load),
    .data_i  (tx_word),
    .shift_i (bit_rise && read_phase),
    .miso_o  (spi_miso_o)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_reg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_s_i,
  input logic              wp_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic              spi_miso_i
);
  assert_strobe_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_rd_i));

  assert_wr_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> !reg_wr_i);

  assert_rd_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i |=> !reg_rd_i);

  assert_wp_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && $past(wp_i)) |-> (reg_addr_i == CTRL_ADDR));

  assert_mapped_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i || reg_rd_i) |-> addr_mapped(reg_addr_i));

  assert_abort_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s_i |=> !(reg_wr_i || reg_rd_i));

  assert_idle_miso_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s_i |=> !spi_miso_i);
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_s_i     (cs_s),
  .wp_i       (wp_i),
  .reg_addr_i (reg_addr_o),
  .reg_wr_i   (reg_wr_o),
  .reg_rd_i   (reg_rd_o),
  .spi_miso_i (spi_miso_o)
);

// File: tb/spi_reg_slave_test.sv
`timescale 1ns/1ps
module spi_reg_slave_test;
  localparam int HALF = 25;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs = 1'b0, mosi = 1'b0;
  logic miso, wp, reg_wr, reg_rd;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  logic [7:0] regs [128];
  logic [7:0] gold [128];
  logic [7:0] wbuf [16];
  logic [14:0] exp_wr [$];
  logic [6:0]  exp_rd [$];
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  spi_reg_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .spi_sclk_i(sclk), .spi_cs_i(cs),
    .spi_mosi_i(mosi), .spi_miso_o(miso), .wp_i(wp),
    .reg_addr_o(reg_addr), .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata),
    .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    if (i == 15) return 8'h3A;
    if (i == 16) return 8'hFF;
    if (i == 17) return 8'hA5;
    return 8'(i * 13 + 5);
  endfunction

  function automatic bit is_mapped(input logic [6:0] a);
    return (a < 7'h12) || (a > 7'h1F);
  endfunction

  function automatic logic [7:0] exp_val(input logic [6:0] a);
    if (!is_mapped(a)) return 8'h00;
    if (a == 7'h0F) return gold[a] & 8'hC7;
    if (a == 7'h10) return gold[a] & 8'h03;
    return gold[a];
  endfunction

  // register file behind the port
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) regs[i] <= init_val(i);
    end else if (reg_wr) begin
      regs[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata = regs[reg_addr];
  assign wp = regs[7'h0F][6];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_wr) begin
        if (exp_wr.size() == 0) check(1'b0, "R2/R4/R6/R8/R11 unexpected write", {reg_addr, reg_wdata}, 0);
        else begin
          logic [14:0] e;
          e = exp_wr.pop_front();
          check({reg_addr, reg_wdata} == e, "R2 write strobe", {reg_addr, reg_wdata}, e);
        end
      end
      if (reg_rd) begin
        if (exp_rd.size() == 0) check(1'b0, "R3/R6/R11 unexpected read", reg_addr, 0);
        else begin
          logic [6:0] e;
          e = exp_rd.pop_front();
          check(reg_addr == e, "R3 read strobe", reg_addr, e);
        end
      end
    end
  end

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - nb; b--) begin
      @(negedge clk); sclk = 1'b1; mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = miso; sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic cs_on();
    @(negedge clk); cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_off();
    @(negedge clk); cs = 1'b0; mosi = 1'b0;
    repeat (8) @(negedge clk);
    check(miso == 1'b0, "R10 miso idle", miso, 0);
  endtask

  task automatic write_burst(input logic [6:0] a, input int n);
    logic [7:0] r;
    logic [6:0] p;
    bit cur_wp;
    cur_wp = gold[7'h0F][6];
    p = a;
    cs_on();
    spi_bits({1'b1, a}, 8, r);
    check(r == 8'h00, "R10 miso during command", r, 0);
    for (int i = 0; i < n; i++) begin
      if (is_mapped(p) && (!cur_wp || p == 7'h0F)) begin
        exp_wr.push_back({p, wbuf[i]});
        gold[p] = wbuf[i];
        if (p == 7'h0F) cur_wp = wbuf[i][6];
      end
      spi_bits(wbuf[i], 8, r);
      check(r == 8'h00, "R10 miso during write", r, 0);
      p = p + 7'd1;
    end
    cs_off();
    check(exp_wr.size() == 0, "R2 all writes seen", exp_wr.size(), 0);
  endtask

  task automatic read_burst(input logic [6:0] a, input int n, input string req);
    logic [7:0] r, e;
    logic [6:0] p;
    p = a;
    cs_on();
    spi_bits({1'b0, a}, 8, r);
    check(r == 8'h00, "R10 miso during command", r, 0);
    for (int i = 0; i < n; i++) begin
      if (is_mapped(p)) exp_rd.push_back(p);
      e = exp_val(p);
      spi_bits(8'h00, 8, r);
      check(r == e, req, r, e);
      p = p + 7'd1;
    end
    cs_off();
    check(exp_rd.size() == 0, "R3 read strobe count", exp_rd.size(), 0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 128; i++) gold[i] = init_val(i);
    repeat (5) @(negedge clk);
    // R9 reset state
    check(reg_wr == 1'b0, "R9 reset wr", reg_wr, 0);
    check(reg_rd == 1'b0, "R9 reset rd", reg_rd, 0);
    check(miso == 1'b0, "R9 reset miso", miso, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R2: time bank write burst, R3 read back
    for (int i = 0; i < 7; i++) wbuf[i] = 8'(8'h31 + i * 8'h11);
    write_burst(7'h00, 7);
    read_burst(7'h00, 7, "R1 R3 time readback");

    // R5 control/status masks
    read_burst(7'h0F, 3, "R5 masked read");

    // R6 unused gap
    read_burst(7'h11, 3, "R6 gap read zero");
    wbuf[0] = 8'h77;
    write_burst(7'h12, 1);

    // R7 wrap
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5B;
    write_burst(7'h7F, 2);
    read_burst(7'h7F, 2, "R7 wrap readback");

    // R4 write protect
    wbuf[0] = 8'h40;
    write_burst(7'h0F, 1);
    wbuf[0] = 8'hEE;
    write_burst(7'h05, 1);
    read_burst(7'h05, 1, "R4 protected target unchanged");
    wbuf[0] = 8'h99; wbuf[1] = 8'h00; wbuf[2] = 8'h01;
    write_burst(7'h0E, 3);
    read_burst(7'h0E, 3, "R4 unprotect mid-burst");

    // R8 aborts in data byte and command byte
    cs_on();
    spi_bits(8'hA1, 8, r);
    spi_bits(8'hFF, 4, r);
    cs_off();
    wbuf[0] = 8'h5A;
    write_burst(7'h21, 1);
    cs_on();
    spi_bits(8'h80, 5, r);
    cs_off();
    read_burst(7'h21, 1, "R8 after abort");

    // RAM window burst
    for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'hC3 ^ (i * 8'h29));
    write_burst(7'h40, 4);
    read_burst(7'h40, 4, "R2 R3 ram burst");

    check(exp_wr.size() == 0 && exp_rd.size() == 0, "R11 queues drained", exp_wr.size() + exp_rd.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule